// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Set/Clear Writes

This block controls 32 general-purpose pins arranged as two banks of 16. Every per-pin control register exists once per bank. A write never needs a read first: the low half of the write word names the pins to set and the high half names the pins to clear. Software can therefore change one pin without a read-modify-write sequence, so there is no race with another agent that changes a different pin.

Each bank holds six control registers: output value, output enable, input enable, two auxiliary output selects and an auxiliary input select. It also has a read-only register of the sampled pad levels and two edge-status registers, one for rising edges and one for falling edges, which are cleared by writing one. The pad inputs pass through a two-flop synchronizer. The synchronized level feeds the readback register, the edge detectors and the auxiliary input path. An availability mask, made of a parameter and a fixed reserved set, removes pins from use entirely.

The bus is a plain 32-bit register port: a word address, a write strobe, write data and combinational read data. A write takes effect at the clock edge on which the strobe is high.

Top module: `gpio_setclr_top`

## Requirements
- R1: After reset every control and status register reads 0, pad_oe is all zero and pad_out is all zero.
- R2: Bit 7 of the byte address (bit 5 of bus_addr) selects the bank: pins 0-15 sit at byte offsets below 0x80 and pins 16-31 sit at the same offset plus 0x80. The byte offsets within a bank are 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C auxiliary output A select, 0x10 auxiliary output B select, 0x14 auxiliary input select, 0x18 readback, 0x1C rising-edge status and 0x20 falling-edge status. Read data bits 31:16 are always 0.
- R3: On a write to a control register, a 1 in data bit n (n = 0..15) sets bank pin n and a 1 in data bit n+16 clears it. Zero bits leave the pin unchanged. A read returns the 16 pin values in bits 15:0.
- R4: If one write carries both the set bit and the clear bit of a pin, the pin ends up cleared.
- R5: On a write to an edge-status register, a 1 in data bit n (n = 0..15) clears the flag of pin n. Bits 31:16 have no effect.
- R6: Readback shows the pad level two clock edges after it is applied. It does not depend on input enable.
- R7: The rising-edge or falling-edge flag of a pin is set one edge after its synchronized level goes 0→1 or 1→0, but only while the pin's input enable bit is 1.
- R8: If an edge is detected on the same edge as a write that clears that flag, the flag stays set.
- R9: pad_oe equals output enable. pad_out takes alt_out_a when select A is set, otherwise alt_out_b when select B is set, otherwise the output value bit.
- R10: A pin that is unavailable (AVAIL_MASK bit 0, or one of the reserved pins 23, 29, 30, 31) reads 0 in every register, ignores writes and is never driven. The default mask 0x0F7FFFFF also removes pin 28.
- R11: alt_in carries the synchronized pad level for pins whose auxiliary input select is 1, and 0 for all other pins.
- R12: Byte offsets 0x24 to 0x7C in a bank read 0, and writes to them have no effect. A write to the readback register also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word address (byte address bits 7:2) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: set mask in 15:0, clear mask in 31:16 |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| alt_out_a | input | 32 | Auxiliary function A output sources |
| alt_out_b | input | 32 | Auxiliary function B output sources |
| alt_in | output | 32 | Synchronized pad levels routed to auxiliary inputs |

## Verification
The bench builds the block with its default parameters: two banks of 16 pins and the 0x0F7FFFFF availability mask. With these values the bench reaches both banks through the one address bit that splits them. It also reaches the reserved pins and the masked pin 28 inside the high bank. Directed sequences put an edge on the same clock edge as a clear write. They also drive both select bits of one pin and apply set and clear masks that overlap. A behavioural model compares every output on every cycle.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int REG_IDX_W = 5;

  // Word index of each register inside one bank.
  typedef enum logic [REG_IDX_W-1:0] {
    RI_OUT_VAL  = 5'd0,
    RI_OUT_EN   = 5'd1,
    RI_IN_EN    = 5'd2,
    RI_AUX_A    = 5'd3,
    RI_AUX_B    = 5'd4,
    RI_AUX_IN   = 5'd5,
    RI_READBACK = 5'd6,
    RI_POS_STS  = 5'd7,
    RI_NEG_STS  = 5'd8,
    RI_NONE     = 5'd31
  } reg_idx_e;

  localparam int CTRL_N = 6;  // set/clear registers occupy indices 0..CTRL_N-1
endpackage

// File: rtl/gpio_setclr_sync.sv
module gpio_setclr_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] level,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign level = lvl_q;
  assign prev  = prev_q;
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int BANK_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANK_W-1:0]     avail,
  input  logic                  wr_hit,
  input  logic [REG_IDX_W-1:0]  reg_idx,
  input  logic [2*BANK_W-1:0]   wr_data,
  input  logic [BANK_W-1:0]     pad_in,
  input  logic [BANK_W-1:0]     fn_a,
  input  logic [BANK_W-1:0]     fn_b,
  output logic [BANK_W-1:0]     pad_out,
  output logic [BANK_W-1:0]     pad_oe,
  output logic [BANK_W-1:0]     fn_in,
  output logic [BANK_W-1:0]     rd_val
);
  // set in low half, clear in high half; clear wins; unavailable pins stay 0
  function automatic logic [BANK_W-1:0] apply_setclr(input logic [BANK_W-1:0] cur,
                                                     input logic [2*BANK_W-1:0] wd,
                                                     input logic [BANK_W-1:0] keep);
    return (cur | wd[BANK_W-1:0]) & ~wd[2*BANK_W-1:BANK_W] & keep;
  endfunction

  // write-one-to-clear, a new event overrides the clear
  function automatic logic [BANK_W-1:0] w1c_next(input logic [BANK_W-1:0] cur,
                                                 input logic [BANK_W-1:0] clr,
                                                 input logic [BANK_W-1:0] evt,
                                                 input logic [BANK_W-1:0] keep);
    return ((cur & ~clr) | evt) & keep;
  endfunction

  function automatic logic [BANK_W-1:0] pad_mux(input logic [BANK_W-1:0] sel_a,
                                                input logic [BANK_W-1:0] sel_b,
                                                input logic [BANK_W-1:0] src_a,
                                                input logic [BANK_W-1:0] src_b,
                                                input logic [BANK_W-1:0] val);
    return (sel_a & src_a) | (~sel_a & sel_b & src_b) | (~sel_a & ~sel_b & val);
  endfunction

  logic [BANK_W-1:0] ctrl_q [CTRL_N];
  logic [BANK_W-1:0] pos_sts_q, neg_sts_q;
  logic [BANK_W-1:0] level, prev;

  // named internal events
  logic [BANK_W-1:0] out_val, out_en, in_en, aux_a, aux_b, aux_in;
  logic [BANK_W-1:0] rise_evt, fall_evt;
  logic [BANK_W-1:0] pos_clr, neg_clr;
  logic              wr_out_val;

  gpio_setclr_sync #(.W(BANK_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_in(pad_in),
    .level (level),
    .prev  (prev)
  );

  for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[g] <= '0;
      else if (wr_hit && (reg_idx == REG_IDX_W'(g)))
        ctrl_q[g] <= apply_setclr(ctrl_q[g], wr_data, avail);
    end
  end

  assign out_val = ctrl_q[int'(RI_OUT_VAL)];
  assign out_en  = ctrl_q[int'(RI_OUT_EN)];
  assign in_en   = ctrl_q[int'(RI_IN_EN)];
  assign aux_a   = ctrl_q[int'(RI_AUX_A)];
  assign aux_b   = ctrl_q[int'(RI_AUX_B)];
  assign aux_in  = ctrl_q[int'(RI_AUX_IN)];
  assign wr_out_val = wr_hit && (reg_idx == RI_OUT_VAL);

  assign rise_evt = level & ~prev & in_en & avail;
  assign fall_evt = ~level & prev & in_en & avail;
  assign pos_clr  = (wr_hit && reg_idx == RI_POS_STS) ? wr_data[BANK_W-1:0] : '0;
  assign neg_clr  = (wr_hit && reg_idx == RI_NEG_STS) ? wr_data[BANK_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_sts_q <= '0;
      neg_sts_q <= '0;
    end else begin
      pos_sts_q <= w1c_next(pos_sts_q, pos_clr, rise_evt, avail);
      neg_sts_q <= w1c_next(neg_sts_q, neg_clr, fall_evt, avail);
    end
  end

  assign pad_oe  = out_en;
  assign pad_out = pad_mux(aux_a, aux_b, fn_a, fn_b, out_val);
  assign fn_in   = level & aux_in & avail;

  always_comb begin
    case (reg_idx)
      RI_OUT_VAL, RI_OUT_EN, RI_IN_EN,
      RI_AUX_A, RI_AUX_B, RI_AUX_IN: rd_val = ctrl_q[reg_idx[2:0]];
      RI_READBACK:                   rd_val = level & avail;
      RI_POS_STS:                    rd_val = pos_sts_q;
      RI_NEG_STS:                    rd_val = neg_sts_q;
      default:                       rd_val = '0;
    endcase
  end

  // ---------------- assertions ----------------
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_val |=> ((out_val & $past(wr_data[2*BANK_W-1:BANK_W])) == '0));

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_val |=> ((out_val & $past(wr_data[BANK_W-1:0] & ~wr_data[2*BANK_W-1:BANK_W] & avail))
                    == $past(wr_data[BANK_W-1:0] & ~wr_data[2*BANK_W-1:BANK_W] & avail)));

  assert_edge_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((pos_sts_q & $past(rise_evt)) == $past(rise_evt)));

  assert_gated_by_ien_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_sts_q & ~$past(pos_sts_q) & ~$past(in_en)) == '0) &&
    ((neg_sts_q & ~$past(neg_sts_q) & ~$past(in_en)) == '0));

  assert_unavail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pos_sts_q | neg_sts_q | fn_in) & ~avail) == '0);
endmodule

// File: rtl/gpio_setclr_top.sv
module gpio_setclr_top
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 16,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] AVAIL_MASK    = 32'h0F7F_FFFF,
  parameter logic [NUM_BANKS*BANK_W-1:0] RESERVED_MASK = 32'hE080_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:2]             bus_addr,
  input  logic                          bus_wr,
  input  logic [2*BANK_W-1:0]           bus_wdata,
  output logic [2*BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
  input  logic [NUM_BANKS*BANK_W-1:0]   alt_out_a,
  input  logic [NUM_BANKS*BANK_W-1:0]   alt_out_b,
  output logic [NUM_BANKS*BANK_W-1:0]   alt_in
);
  localparam int SEL_W  = $clog2(NUM_BANKS);
  localparam int OFS_W  = ADDR_W - SEL_W;
  localparam int WORD_W = OFS_W - 2;
  localparam logic [NUM_BANKS*BANK_W-1:0] EFF_AVAIL = AVAIL_MASK & ~RESERVED_MASK;

  function automatic logic [REG_IDX_W-1:0] decode_word(input logic [WORD_W-1:0] w);
    if (int'(w) <= int'(RI_NEG_STS)) return REG_IDX_W'(w);
    return RI_NONE;
  endfunction

  logic [SEL_W-1:0]     bank_sel;
  logic [WORD_W-1:0]    word;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];

  assign bank_sel = bus_addr[ADDR_W-1 -: SEL_W];
  assign word     = bus_addr[OFS_W-1:2];
  assign reg_idx  = decode_word(word);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_setclr_bank #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .avail  (EFF_AVAIL[b*BANK_W +: BANK_W]),
      .wr_hit (bus_wr && (bank_sel == SEL_W'(b))),
      .reg_idx(reg_idx),
      .wr_data(bus_wdata),
      .pad_in (pad_in[b*BANK_W +: BANK_W]),
      .fn_a   (alt_out_a[b*BANK_W +: BANK_W]),
      .fn_b   (alt_out_b[b*BANK_W +: BANK_W]),
      .pad_out(pad_out[b*BANK_W +: BANK_W]),
      .pad_oe (pad_oe[b*BANK_W +: BANK_W]),
      .fn_in  (alt_in[b*BANK_W +: BANK_W]),
      .rd_val (bank_rd[b])
    );
  end

  assign bus_rdata = {{BANK_W{1'b0}}, bank_rd[bank_sel]};
endmodule

// File: tb/tb_gpio_setclr_top.sv
`timescale 1ns/1ps
module tb_gpio_setclr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:2]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic [31:0] alt_out_a = '0, alt_out_b = '0, alt_in;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_setclr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out_a(alt_out_a),
    .alt_out_b(alt_out_b), .alt_in(alt_in)
  );

  // ---------------- reference model ----------------
  localparam logic [31:0] AV = 32'h0F7F_FFFF & ~32'hE080_0000;
  logic [15:0] m_reg [2][9];
  logic [31:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;

  function automatic logic [15:0] av_of(int b);
    return AV[b*16 +: 16];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) for (int r = 0; r < 9; r++) m_reg[b][r] = '0;
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
    end else begin
      logic [31:0] ien, rise, fall;
      int b, w;
      ien  = {m_reg[1][2], m_reg[0][2]};
      rise = m_s2 & ~m_s3 & ien;
      fall = ~m_s2 & m_s3 & ien;
      if (bus_wr) begin
        b = int'(bus_addr[7]);
        w = int'(bus_addr[6:2]);
        if (w <= 5)
          m_reg[b][w] = (m_reg[b][w] | bus_wdata[15:0]) & ~bus_wdata[31:16] & av_of(b);
        else if (w == 7 || w == 8)
          m_reg[b][w] = m_reg[b][w] & ~bus_wdata[15:0];
      end
      for (int k = 0; k < 2; k++) begin
        m_reg[k][7] = m_reg[k][7] | (rise[k*16 +: 16] & av_of(k));
        m_reg[k][8] = m_reg[k][8] | (fall[k*16 +: 16] & av_of(k));
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
  end

  function automatic logic [31:0] m_read(logic [7:2] a);
    int b, w;
    b = int'(a[7]);
    w = int'(a[6:2]);
    if (w <= 5 || w == 7 || w == 8) return {16'h0, m_reg[b][w]};
    if (w == 6) return {16'h0, m_s2[b*16 +: 16] & av_of(b)};
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_pad_out();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      int b, i;
      b = p / 16; i = p % 16;
      if (m_reg[b][3][i])      r[p] = alt_out_a[p];
      else if (m_reg[b][4][i]) r[p] = alt_out_b[p];
      else                     r[p] = m_reg[b][0][i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R2 model bus_rdata", bus_rdata, m_read(bus_addr));
      check("R9 model pad_oe", pad_oe, {m_reg[1][1], m_reg[0][1]});
      check("R9 model pad_out", pad_out, m_pad_out());
      check("R11 model alt_in", alt_in, m_s2 & {m_reg[1][5], m_reg[0][5]} & AV);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[7:2]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a[7:2];
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    read_chk(8'h00, 32'h0, "R1 out_val after reset");
    read_chk(8'h9C, 32'h0, "R1 high pos status after reset");
    check("R1 pad_oe after reset", pad_oe, 32'h0);
    check("R1 pad_out after reset", pad_out, 32'h0);

    // R3 set then partial clear
    bus_write(8'h04, 32'h0000_00F5);
    read_chk(8'h04, 32'h0000_00F5, "R3 set mask");
    bus_write(8'h04, 32'h0005_0000);
    read_chk(8'h04, 32'h0000_00F0, "R3 clear mask leaves others");
    check("R9 pad_oe follows out_en", pad_oe, 32'h0000_00F0);

    // R4 overlap: clear wins
    bus_write(8'h00, 32'h0000_000C);
    bus_write(8'h00, 32'h0004_0005);
    read_chk(8'h00, 32'h0000_0009, "R4 clear wins on overlap");
    check("R9 pad_out from out_val", pad_out, 32'h0000_0009);

    // R9 aux priority
    alt_out_a = 32'hFFFF_FFFF; alt_out_b = 32'h0;
    bus_write(8'h0C, 32'h0000_0001);
    bus_write(8'h10, 32'h0000_0009);
    wait_cyc(1);
    check("R9 aux A over aux B over out_val", pad_out, 32'h0000_0001);

    // R2 high bank decode
    bus_write(8'h84, 32'h0000_0001);
    read_chk(8'h84, 32'h0000_0001, "R2 high bank out_en");
    read_chk(8'h04, 32'h0000_00F0, "R2 low bank untouched");
    check("R2 high bank pad_oe", pad_oe, 32'h0001_00F0);

    // R10 reserved / masked pins
    bus_write(8'h80, 32'h0000_FFFF);
    read_chk(8'h80, 32'h0000_0F7F, "R10 unavailable pins read zero");
    bus_write(8'h84, 32'h0000_FFFF);
    wait_cyc(1);
    check("R10 unavailable pins never driven", pad_oe & ~AV, 32'h0);

    // R6 synchronizer latency, in_en still 0
    @(negedge clk);
    pad_in = 32'h0000_00A5;
    bus_addr = 6'(8'h18 >> 2);
    @(negedge clk); #1;
    check("R6 readback not yet after one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R6 readback after two edges", bus_rdata, 32'h0000_00A5);

    // R7 no flag without input enable
    wait_cyc(3);
    read_chk(8'h1C, 32'h0, "R7 no rising flag while input disabled");
    bus_write(8'h08, 32'h0000_00FF);
    @(negedge clk); pad_in = 32'h0000_00A7;
    wait_cyc(4);
    read_chk(8'h1C, 32'h0000_0002, "R7 rising flag");
    @(negedge clk); pad_in = 32'h0000_00A3;
    wait_cyc(4);
    read_chk(8'h20, 32'h0000_0004, "R7 falling flag");

    // R5 write-one-to-clear
    bus_write(8'h1C, 32'hFFFF_0000);
    read_chk(8'h1C, 32'h0000_0002, "R5 high half ignored");
    bus_write(8'h1C, 32'h0000_0002);
    read_chk(8'h1C, 32'h0, "R5 clear flag");
    bus_write(8'h20, 32'h0000_FFFF);
    read_chk(8'h20, 32'h0, "R5 clear falling flags");

    // R8 edge coinciding with clear
    @(negedge clk); pad_in = 32'h0000_00E3;
    wait_cyc(4);
    read_chk(8'h1C, 32'h0000_0040, "R8 setup rise");
    @(negedge clk); pad_in = 32'h0000_00A3;
    wait_cyc(4);
    @(negedge clk); pad_in = 32'h0000_00E3;
    wait_cyc(2);
    bus_addr = 6'(8'h1C >> 2); bus_wdata = 32'h0000_0040; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    #1;
    check("R8 edge beats clear", bus_rdata, 32'h0000_0040);
    bus_write(8'h1C, 32'h0000_0040);
    read_chk(8'h1C, 32'h0, "R8 clear without edge");

    // R11 aux input routing
    bus_write(8'h14, 32'h0000_0020);
    wait_cyc(1);
    check("R11 alt_in routed", alt_in, 32'h0000_0020);

    // R12 unmapped offsets and readback writes
    bus_write(8'h2C, 32'h0000_FFFF);
    read_chk(8'h2C, 32'h0, "R12 unmapped reads zero");
    bus_write(8'h18, 32'h00E3_001C);
    read_chk(8'h18, 32'h0000_00E3, "R12 readback ignores writes");
    read_chk(8'h00, 32'h0000_0009, "R12 out_val unaffected");

    wait_cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule